// File: doc/BRIEF.md
# Prioritized Serial Interrupt Identifier

This block merges the interrupt causes of a byte-oriented asynchronous serial port into one active-high interrupt line. It also produces an identification byte that software reads to learn which cause is most urgent. Each cause has its own pending state and its own clearing action, which is driven by strobes from the register decode around the block.

The block contains the receive idle timer. The timer watches a receive FIFO that holds some data but has not reached its trigger level. It counts bit-period ticks, and after four character times with no new character and no read, it raises a timeout cause.

The FIFOs, the shift engines and the register file live outside this block. It receives the FIFO level, event pulses and the enable nibble as inputs.

Top module: `serial_irq_ident`

## Requirements
- R1: Enable bit 0 (`src_en[0]`) gates received-data and timeout, bit 1 gates transmit-empty, bit 2 gates line status, and bit 3 gates modem status. A disabled cause is never reported. Its pending state is still recorded, so it is reported once its enable bit is set.
- R2: `irq` is high exactly when `ident[0]` is 0. With nothing pending, `ident[3:0]` is 4'b0001.
- R3: Only the highest-priority pending cause is reported in `ident[3:0]`. The order from highest to lowest, with codes, is: line status 4'b0110, received data 4'b0100, timeout 4'b1100, transmit empty 4'b0010, modem status 4'b0000.
- R4: Line status becomes pending in the cycle after an `lsr_event` pulse. It is cleared by `lsr_rd`, and a same-cycle event wins over the clear.
- R5: Received data is reported, with no register delay, while `rx_level` is at least the trigger. With `fifo_on` high, `trig_sel` 2'b00/01/10/11 gives a trigger of 1/4/8/14 (2'b10 is FIFO-control value 0x80). With `fifo_on` low, the trigger is 1.
- R6: With `fifo_on` high and `rx_level` nonzero but below the trigger, timeout becomes pending in the cycle after the 4*`char_bits`-th `baud_tick`. `rbr_rd` clears it, and so does leaving that level window.
- R7: The timeout count restarts on every `rx_push` and every `rbr_rd`.
- R8: Transmit-empty becomes pending on a rising edge of `thr_empty`, or when `src_en[1]` rises while `thr_empty` is high. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where code 4'b0010 is reported. Setting wins over clearing.
- R9: Modem status becomes pending after an `msr_event` pulse and is cleared by `msr_rd`.
- R10: `ident[7:6]` is 2'b11 while `fifo_on` is high and 2'b00 otherwise. `ident[5:4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_en | input | 4 | Interrupt enable bits |
| fifo_on | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive trigger select |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_push | input | 1 | Character entered receive FIFO |
| rbr_rd | input | 1 | Receive buffer read strobe |
| lsr_event | input | 1 | Receive line error detected |
| lsr_rd | input | 1 | Line status read strobe |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Transmit holding write strobe |
| iir_rd | input | 1 | Identification byte read strobe |
| msr_event | input | 1 | Modem status changed |
| msr_rd | input | 1 | Modem status read strobe |
| baud_tick | input | 1 | One pulse per bit period |
| char_bits | input | CB_W | Bits per character frame |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Timeout threshold.** The timeout must appear at exactly tick 4*`char_bits` and not one tick early. An off-by-one counter would report code 4'b1100 a cycle too soon or too late.
- **Timer restart.** A push late in the idle window must restart the count. A design that ignored the push would time out while characters are still arriving.
- **Identification-read clear.** A read of the identification byte while line status outranks transmit-empty must leave transmit-empty pending. A design that cleared it anyway would lose the transmit interrupt.
- **Trigger boundaries.** Levels 7/8 and 13/14 are driven against the trigger, and a cause latched while disabled must appear when its enable bit is set. A wrong comparison shows up as received-data reported one level off.

// File: rtl/serial_irq_ident.sv
module serial_irq_ident #(
  parameter int LVL_W = 5,
  parameter int CB_W  = 4,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       src_en,
  input  logic             fifo_on,
  input  logic [1:0]       trig_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             lsr_event,
  input  logic             lsr_rd,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             msr_event,
  input  logic             msr_rd,
  input  logic             baud_tick,
  input  logic [CB_W-1:0]  char_bits,
  output logic [7:0]       ident,
  output logic             irq
);
  localparam logic [3:0] C_LS = 4'b0110, C_RD = 4'b0100, C_TO = 4'b1100,
                         C_TE = 4'b0010, C_MS = 4'b0000, C_NONE = 4'b0001;

  logic ls_f, ms_f, te_f, to_f, thr_q, en1_q;
  logic [CNT_W-1:0] cnt;
  logic [LVL_W-1:0] trig;
  logic [3:0] code;

  always_comb
    case (fifo_on ? trig_sel : 2'b00)
      2'b00:   trig = LVL_W'(1);
      2'b01:   trig = LVL_W'(4);
      2'b10:   trig = LVL_W'(8);
      default: trig = LVL_W'(14);
    endcase

  wire [CNT_W-1:0] lim = CNT_W'({char_bits, 2'b00});
  wire rd_hit  = src_en[0] && (rx_level >= trig);
  wire armed   = fifo_on && (rx_level != '0) && (rx_level < trig);
  wire te_set  = thr_empty && (!thr_q || (src_en[1] && !en1_q));

  always_comb
    if      (ls_f && src_en[2]) code = C_LS;
    else if (rd_hit)            code = C_RD;
    else if (to_f && src_en[0]) code = C_TO;
    else if (te_f && src_en[1]) code = C_TE;
    else if (ms_f && src_en[3]) code = C_MS;
    else                        code = C_NONE;

  assign ident = {{2{fifo_on}}, 2'b00, code};
  assign irq   = !code[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ls_f <= 1'b0; ms_f <= 1'b0; te_f <= 1'b0; to_f <= 1'b0;
      thr_q <= 1'b1; en1_q <= 1'b0; cnt <= '0;
    end else begin
      if (lsr_event) ls_f <= 1'b1; else if (lsr_rd) ls_f <= 1'b0;
      if (msr_event) ms_f <= 1'b1; else if (msr_rd) ms_f <= 1'b0;
      if (te_set) te_f <= 1'b1;
      else if (thr_wr || (iir_rd && code == C_TE)) te_f <= 1'b0;
      thr_q <= thr_empty;
      en1_q <= src_en[1];
      if (!armed || rbr_rd) to_f <= 1'b0;
      else if (baud_tick && !rx_push && cnt == lim - 1'b1) to_f <= 1'b1;
      if (!armed || rx_push || rbr_rd) cnt <= '0;
      else if (baud_tick && cnt != lim) cnt <= cnt + 1'b1;
    end
endmodule

module serial_irq_ident_chk #(
  parameter int LVL_W = 5,
  parameter int CB_W  = 4,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       src_en,
  input logic             fifo_on,
  input logic [1:0]       trig_sel,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_push,
  input logic             rbr_rd,
  input logic             lsr_event,
  input logic             lsr_rd,
  input logic             thr_empty,
  input logic             thr_wr,
  input logic             iir_rd,
  input logic             msr_event,
  input logic             msr_rd,
  input logic             baud_tick,
  input logic [CB_W-1:0]  char_bits,
  input logic [7:0]       ident,
  input logic             irq
);
  assert_ls_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_en[2] && $past(lsr_event) |-> ident[3:0] == 4'b0110);
  assert_ls_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lsr_rd && !lsr_event) |-> ident[3:0] != 4'b0110);
  assert_irq_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> src_en != 4'b0000);
  assert_to_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rbr_rd) |-> ident[3:0] != 4'b1100);
  assert_te_write_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && $stable(thr_empty) && $stable(src_en[1]) |=> ident[3:0] != 4'b0010);
  assert_high_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ident[5:4] == 2'b00);
endmodule

bind serial_irq_ident serial_irq_ident_chk #(.LVL_W(LVL_W), .CB_W(CB_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_serial_irq_ident.sv
module test_serial_irq_ident;
  logic clk = 0, rst_n = 0;
  logic [3:0] src_en = 0;
  logic fifo_on = 0;
  logic [1:0] trig_sel = 0;
  logic [4:0] rx_level = 0;
  logic rx_push = 0, rbr_rd = 0, lsr_event = 0, lsr_rd = 0, thr_empty = 1;
  logic thr_wr = 0, iir_rd = 0, msr_event = 0, msr_rd = 0, baud_tick = 0;
  logic [3:0] char_bits = 4'd2;
  logic [7:0] ident;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  logic m_ls = 0, m_ms = 0, m_te = 0, m_to = 0, m_thr = 1, m_en1 = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  serial_irq_ident i_serial_irq_ident (.*);

  function automatic int trigf();
    if (!fifo_on) return 1;
    case (trig_sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [3:0] mcode();
    if (m_ls && src_en[2]) return 4'b0110;
    if (src_en[0] && int'(rx_level) >= trigf()) return 4'b0100;
    if (m_to && src_en[0]) return 4'b1100;
    if (m_te && src_en[1]) return 4'b0010;
    if (m_ms && src_en[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic upd();
    logic [3:0] c = mcode();
    bit armed = fifo_on && rx_level != 0 && int'(rx_level) < trigf();
    int lim = 4 * int'(char_bits);
    if (lsr_event) m_ls = 1; else if (lsr_rd) m_ls = 0;
    if (msr_event) m_ms = 1; else if (msr_rd) m_ms = 0;
    if (thr_empty && (!m_thr || (src_en[1] && !m_en1))) m_te = 1;
    else if (thr_wr || (iir_rd && c == 4'b0010)) m_te = 0;
    m_thr = thr_empty; m_en1 = src_en[1];
    if (!armed || rbr_rd) m_to = 0;
    else if (baud_tick && !rx_push && m_cnt == lim - 1) m_to = 1;
    if (!armed || rx_push || rbr_rd) m_cnt = 0;
    else if (baud_tick && m_cnt != lim) m_cnt++;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    upd();
    @(negedge clk);
    chk(ident, {{2{fifo_on}}, 2'b00, mcode()}, "R3 model ident");
    chk({7'd0, irq}, {7'd0, !mcode()[0]}, "R2 model irq");
    rx_push = 0; rbr_rd = 0; lsr_event = 0; lsr_rd = 0; thr_wr = 0;
    iir_rd = 0; msr_event = 0; msr_rd = 0; baud_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin baud_tick = 1; cyc(); end
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ident, 8'h01, "R2 reset ident");
    chk({7'd0, irq}, 8'h00, "R2 reset irq");
    rst_n = 1;
    cyc();

    src_en = 4'b0100; lsr_event = 1; cyc();
    chk(ident, 8'h06, "R4 line status raised");
    lsr_rd = 1; cyc();
    chk(ident, 8'h01, "R4 line status cleared");
    lsr_event = 1; lsr_rd = 1; cyc();
    chk(ident, 8'h06, "R4 event wins over read");
    lsr_rd = 1; cyc();

    src_en = 4'b0000; lsr_event = 1; cyc();
    chk(ident, 8'h01, "R1 disabled cause hidden");
    src_en = 4'b0100; cyc();
    chk(ident, 8'h06, "R1 latched cause shown on enable");
    lsr_rd = 1; cyc();

    src_en = 4'b0001; fifo_on = 1; trig_sel = 2'b10; rx_level = 7; cyc();
    chk(ident, 8'hC1, "R5 level 7 below trigger 8");
    rx_level = 8; cyc();
    chk(ident, 8'hC4, "R5 level 8 meets trigger 8");
    trig_sel = 2'b11; rx_level = 13; cyc();
    rbr_rd = 1; cyc();
    chk(ident, 8'hC1, "R5 level 13 below trigger 14");
    rx_level = 14; cyc();
    chk(ident, 8'hC4, "R5 level 14 meets trigger 14");
    fifo_on = 0; rx_level = 1; cyc();
    chk(ident, 8'h04, "R5 fifo off trigger 1");
    chk({7'd0, irq}, 8'h01, "R2 irq with code 0100");

    src_en = 4'b0101; fifo_on = 1; lsr_event = 1; rx_level = 14; cyc();
    chk(ident, 8'hC6, "R3 line status over data");
    lsr_rd = 1; cyc();
    chk(ident, 8'hC4, "R3 data after line status clear");

    src_en = 4'b0001; trig_sel = 2'b10; rx_level = 3; char_bits = 2; cyc(); cyc();
    ticks(7);
    chk(ident, 8'hC1, "R6 no timeout at tick 7");
    ticks(1);
    chk(ident, 8'hCC, "R6 timeout at tick 8");
    rbr_rd = 1; cyc();
    chk(ident, 8'hC1, "R6 read clears timeout");
    ticks(7);
    rx_push = 1; cyc();
    ticks(7);
    chk(ident, 8'hC1, "R7 push restarts timer");
    ticks(1);
    chk(ident, 8'hCC, "R7 timeout after restart");
    rbr_rd = 1; rx_level = 0; cyc();

    src_en = 4'b0010; thr_empty = 0; cyc();
    thr_empty = 1; cyc();
    chk(ident, 8'hC2, "R8 raised on empty edge");
    thr_wr = 1; cyc();
    chk(ident, 8'hC1, "R8 cleared by write");
    src_en = 4'b0000; cyc();
    src_en = 4'b0010; cyc();
    chk(ident, 8'hC2, "R8 raised on enable while empty");
    iir_rd = 1; cyc();
    chk(ident, 8'hC1, "R8 cleared by ident read");
    src_en = 4'b0110; lsr_event = 1; thr_empty = 0; cyc();
    thr_empty = 1; cyc();
    chk(ident, 8'hC6, "R3 line status over transmit");
    iir_rd = 1; cyc();
    lsr_rd = 1; cyc();
    chk(ident, 8'hC2, "R8 ident read while outranked keeps it");
    thr_wr = 1; cyc();

    src_en = 4'b1000; msr_event = 1; cyc();
    chk(ident, 8'hC0, "R9 modem raised");
    chk({7'd0, irq}, 8'h01, "R2 irq with code 0000");
    msr_rd = 1; cyc();
    chk(ident, 8'hC1, "R9 modem cleared");
    fifo_on = 0; cyc();
    chk(ident, 8'h01, "R10 fifo off high bits");

    void'($urandom(32'd2024));
    char_bits = 2;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) src_en = 4'($urandom);
      if ($urandom_range(0, 40) == 0) fifo_on = 1'($urandom);
      if ($urandom_range(0, 30) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(0, 25) == 0) rx_level = 5'($urandom_range(0, 15));
      if ($urandom_range(0, 10) == 0) thr_empty = 1'($urandom);
      rx_push   = ($urandom_range(0, 30) == 0);
      rbr_rd    = ($urandom_range(0, 30) == 0);
      lsr_event = ($urandom_range(0, 40) == 0);
      lsr_rd    = ($urandom_range(0, 15) == 0);
      thr_wr    = ($urandom_range(0, 20) == 0);
      iir_rd    = ($urandom_range(0, 10) == 0);
      msr_event = ($urandom_range(0, 40) == 0);
      msr_rd    = ($urandom_range(0, 15) == 0);
      baud_tick = 1'($urandom);
      cyc();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule